// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm Compare

This peripheral keeps time for a chip from a slow reference. A reference-enable input marks each edge of the 32.768 kHz reference. That input is modelled as a clock enable in the bus clock domain. The programmable prescaler divides those enables down to a slow tick. Each tick advances a 32-bit free-running counter. The divider's reset value gives 16 ticks per second, so the low four bits of the counter are a sixteenth-of-a-second fraction and the whole seconds are the count shifted right by four.

Two alarm compare registers watch the counter. A single status word holds three sticky event flags next to their enable bits: alarm 0, alarm 1 and tick. Software clears a flag by writing 1 to it. A level interrupt is raised while any enabled flag is set. The register set also holds a clock-source select, which must hold the reference code before the prescaler runs, and a scratch word that software uses to keep an epoch count across counter wraps. All access goes through a simple synchronous register port.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset these registers read 0: counter, both alarms, status, clock select and scratch. The divider reads 1023, and the interrupt output is low.
- R2: The prescaler runs only while clock select holds 3. While it runs, it gives one tick for every 2*(DIV+1) cycles in which the reference enable is high. With the enable held high and DIV=1 that is one tick every 4 cycles, and with DIV=2 one every 6.
- R3: The counter adds 1 on the edge of each tick, holds its value otherwise, and wraps from 0xFFFFFFFF to 0.
- R4: A write to the counter (offset 0x00) loads the written value at that edge. A write to the counter or to the divider (offset 0x0C) restarts the prescaler phase, so the next tick comes a full period after the write edge.
- R5: Alarm 0 (offset 0x04) and alarm 1 (offset 0x18) each set their flag on the edge at which the counter takes a value equal to the alarm value, but only while that alarm's enable bit is set. With the enable clear, no flag is set.
- R6: The tick flag, status bit 1, is set on every tick whether or not its enable, bit 3, is set.
- R7: In the status word (offset 0x08), writing 1 to a flag bit (bit 0 alarm 0, bit 1 tick, bit 4 alarm 1) clears it, and writing 0 leaves it unchanged. When a set event and a clearing write fall on the same edge, the flag stays set.
- R8: The enable bits are plain read/write bits: bit 2 alarm 0, bit 3 tick, bit 6 alarm 1. Status bit 5 and bits 7 to 31 always read 0.
- R9: The interrupt output is high exactly while at least one flag is set together with its own enable bit.
- R10: Clock select (offset 0x1C) is a 2-bit read/write register. The value 3 selects the reference clock. With any other value the counter does not advance.
- R11: The scratch word (offset 0x40) reads back what was written to it. Reads of any unmapped offset return 0, and writes to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle enable per reference clock edge |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 16-bit divider resetting to 1023 and 8-bit offsets. It holds the reference enable high and reprograms the divider to 1 and 2 at run time, so ticks come every 4 or 6 cycles. That makes exact tick edges predictable, which lets the bench land a status write precisely on a tick edge for the set-over-clear case. Loading the counter with all ones brings the wrap within four cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register byte offsets
  localparam int OFF_COUNT = 'h00;
  localparam int OFF_ALM0  = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_DIV   = 'h0C;
  localparam int OFF_ALM1  = 'h18;
  localparam int OFF_CSEL  = 'h1C;
  localparam int OFF_SCR   = 'h40;

  // Clock-select code that lets the prescaler run
  localparam int CSEL_REF  = 3;

  // Status events: index 0 alarm0, 1 tick, 2 alarm1
  localparam int N_EVT = 3;
  localparam int EV_ALM0 = 0;
  localparam int EV_TICK = 1;
  localparam int EV_ALM1 = 2;

  function automatic int flag_pos(input int ev);
    case (ev)
      EV_ALM0: flag_pos = 0;
      EV_TICK: flag_pos = 1;
      default: flag_pos = 4;
    endcase
  endfunction

  function automatic int en_pos(input int ev);
    case (ev)
      EV_ALM0: en_pos = 2;
      EV_TICK: en_pos = 3;
      default: en_pos = 6;
    endcase
  endfunction

  function automatic int alarm_off(input int idx);
    alarm_off = (idx == 0) ? OFF_ALM0 : OFF_ALM1;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PH_W = DIV_W + 1;

  // Last phase of a 2*(div+1) period is 2*div+1.
  function automatic logic [PH_W-1:0] last_phase(input logic [DIV_W-1:0] d);
    last_phase = {d, 1'b1};
  endfunction

  logic [PH_W-1:0] phase_q;
  logic            at_last;

  assign at_last = (phase_q == last_phase(div_i));
  assign tick_o  = run_i && !restart_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i) begin
      phase_q <= '0;
    end else if (run_i) begin
      phase_q <= at_last ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cnt_upd_i,
  input  logic [W-1:0] cnt_next_i,
  input  logic         en_i,
  output logic         hit_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0] value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value_q <= '0;
    else if (wr_i) value_q <= wdata_i;
  end

  // Hit on the edge at which the counter takes on the alarm value.
  assign hit_o   = en_i && cnt_upd_i && (cnt_next_i == value_q);
  assign value_o = value_q;
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
  parameter int NE = rtc_pkg::N_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] set_i,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [NE-1:0] flag_o,
  output logic [NE-1:0] en_o,
  output logic [31:0]   word_o,
  output logic          irq_o
);
  logic [NE-1:0] flag_q;
  logic [NE-1:0] en_q;
  logic          unused_wd;

  assign unused_wd = ^wdata_i;

  for (genvar e = 0; e < NE; e++) begin : g_evt
    localparam int FP = rtc_pkg::flag_pos(e);
    localparam int EP = rtc_pkg::en_pos(e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[e] <= 1'b0;
        en_q[e]   <= 1'b0;
      end else begin
        if (set_i[e])                 flag_q[e] <= 1'b1;
        else if (wr_i && wdata_i[FP]) flag_q[e] <= 1'b0;
        if (wr_i)                     en_q[e]   <= wdata_i[EP];
      end
    end
  end

  always_comb begin
    word_o = '0;
    for (int e = 0; e < NE; e++) begin
      word_o[rtc_pkg::flag_pos(e)] = flag_q[e];
      word_o[rtc_pkg::en_pos(e)]   = en_q[e];
    end
  end

  assign irq_o  = |(flag_q & en_q);
  assign flag_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32,
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 1023,
  parameter int CSEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import rtc_pkg::*;

  localparam int N_ALM = 2;

  function automatic logic [CNT_W-1:0] count_next(
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cur);
    count_next = load ? load_val : cur + 1'b1;
  endfunction

  function automatic logic addr_is(input logic [ADDR_W-1:0] a, input int off);
    addr_is = (a == ADDR_W'(off));
  endfunction

  // Register storage
  logic [CNT_W-1:0]  count_q;
  logic [DIV_W-1:0]  div_q;
  logic [CSEL_W-1:0] csel_q;
  logic [31:0]       scratch_q;

  // Named internal events
  logic              cnt_wr_w, div_wr_w, stat_wr_w;
  logic              tick_w, run_w, restart_w, cnt_upd_w;
  logic [CNT_W-1:0]  cnt_next_w;
  logic [N_ALM-1:0]  alm_hit_w;
  logic [CNT_W-1:0]  alm_val_w [N_ALM];
  logic [N_EVT-1:0]  flag_w, en_w, set_w;
  logic [31:0]       stat_word_w;

  assign cnt_wr_w  = bus_wr && addr_is(bus_addr, OFF_COUNT);
  assign div_wr_w  = bus_wr && addr_is(bus_addr, OFF_DIV);
  assign stat_wr_w = bus_wr && addr_is(bus_addr, OFF_STAT);
  assign run_w     = ref_en && (csel_q == CSEL_W'(CSEL_REF));
  assign restart_w = cnt_wr_w || div_wr_w;
  assign cnt_upd_w = cnt_wr_w || tick_w;
  assign cnt_next_w = count_next(cnt_wr_w, bus_wdata[CNT_W-1:0], count_q);

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_w),
    .restart_i (restart_w),
    .div_i     (div_q),
    .tick_o    (tick_w)
  );

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    localparam int EV = (g == 0) ? EV_ALM0 : EV_ALM1;
    rtc_alarm_cmp #(.W(CNT_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr && addr_is(bus_addr, alarm_off(g))),
      .wdata_i    (bus_wdata[CNT_W-1:0]),
      .cnt_upd_i  (cnt_upd_w),
      .cnt_next_i (cnt_next_w),
      .en_i       (en_w[EV]),
      .hit_o      (alm_hit_w[g]),
      .value_o    (alm_val_w[g])
    );
  end

  always_comb begin
    set_w          = '0;
    set_w[EV_ALM0] = alm_hit_w[0];
    set_w[EV_TICK] = tick_w;
    set_w[EV_ALM1] = alm_hit_w[1];
  end

  rtc_status #(.NE(N_EVT)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_w),
    .wr_i    (stat_wr_w),
    .wdata_i (bus_wdata),
    .flag_o  (flag_w),
    .en_o    (en_w),
    .word_o  (stat_word_w),
    .irq_o   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      div_q     <= DIV_W'(DIV_RST);
      csel_q    <= '0;
      scratch_q <= '0;
    end else begin
      if (cnt_upd_w) count_q <= cnt_next_w;
      if (div_wr_w)  div_q   <= bus_wdata[DIV_W-1:0];
      if (bus_wr && addr_is(bus_addr, OFF_CSEL)) csel_q    <= bus_wdata[CSEL_W-1:0];
      if (bus_wr && addr_is(bus_addr, OFF_SCR))  scratch_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_is(bus_addr, OFF_COUNT))     bus_rdata[CNT_W-1:0]  = count_q;
    else if (addr_is(bus_addr, OFF_ALM0)) bus_rdata[CNT_W-1:0]  = alm_val_w[0];
    else if (addr_is(bus_addr, OFF_ALM1)) bus_rdata[CNT_W-1:0]  = alm_val_w[1];
    else if (addr_is(bus_addr, OFF_STAT)) bus_rdata             = stat_word_w;
    else if (addr_is(bus_addr, OFF_DIV))  bus_rdata[DIV_W-1:0]  = div_q;
    else if (addr_is(bus_addr, OFF_CSEL)) bus_rdata[CSEL_W-1:0] = csel_q;
    else if (addr_is(bus_addr, OFF_SCR))  bus_rdata             = scratch_q;
  end
endmodule

// File: rtl/rtc_alarm_counter_chk.sv
module rtc_alarm_counter_chk #(
  parameter int W  = 32,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_wr,
  input logic [W-1:0]  count,
  input logic [CW-1:0] csel,
  input logic [2:0]    flags,
  input logic [1:0]    hits,
  input logic          stat_wr,
  input logic          irq
);
  assert_tick_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (csel == CW'(rtc_pkg::CSEL_REF)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count == W'($past(count) + 1'b1)));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  assert_alm0_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(hits[0]));

  assert_alm1_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(hits[1]));

  assert_tick_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags[1]);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !stat_wr) |=> flags[0]);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(flags) > 0));
endmodule

bind rtc_alarm_counter rtc_alarm_counter_chk #(.W(CNT_W), .CW(CSEL_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .cnt_wr  (cnt_wr_w),
  .count   (count_q),
  .csel    (csel_q),
  .flags   (flag_w),
  .hits    (alm_hit_w),
  .stat_wr (stat_wr_w),
  .irq     (irq)
);

// File: tb/rtc_alarm_counter_tb_top.sv
module rtc_alarm_counter_tb_top;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CNT = 8'h00, A_AL0 = 8'h04, A_ST = 8'h08, A_DIV = 8'h0C,
                         A_AL1 = 8'h18, A_CS = 8'h1C, A_SCR = 8'h40, A_NONE = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_alarm_counter dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v); check("R1 counter", v, 0);
    rd(A_AL0, v); check("R1 alarm0", v, 0);
    rd(A_AL1, v); check("R1 alarm1", v, 0);
    rd(A_ST, v);  check("R1 status", v, 0);
    rd(A_DIV, v); check("R1 divider", v, 1023);
    rd(A_CS, v);  check("R1 clksel", v, 0);
    rd(A_SCR, v); check("R1 scratch", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_tick_period();
    logic [31:0] v;
    wr(A_CS, 3);  rd(A_CS, v); check("R10 clksel readback", v, 3);
    wr(A_DIV, 1); rd(A_DIV, v); check("R4 divider readback", v, 1);
    wr(A_CNT, 100);
    rd(A_CNT, v); check("R4 counter load", v, 100);
    cycles(3); rd(A_CNT, v); check("R2 no tick before period", v, 100);
    cycles(1); rd(A_CNT, v); check("R3 tick after 4 cycles", v, 101);
    cycles(4); rd(A_CNT, v); check("R2 second tick", v, 102);
    wr(A_DIV, 2);
    cycles(5); rd(A_CNT, v); check("R4 divider write restarts phase", v, 102);
    cycles(1); rd(A_CNT, v); check("R2 period 6 with DIV=2", v, 103);
    wr(A_DIV, 1);
  endtask

  task automatic t_clksel();
    logic [31:0] v;
    wr(A_CS, 0);
    wr(A_CNT, 5);
    cycles(20); rd(A_CNT, v); check("R10 frozen when clksel!=3", v, 5);
    wr(A_CS, 1); rd(A_CS, v); check("R10 clksel holds 1", v, 1);
    cycles(8);  rd(A_CNT, v); check("R10 frozen with clksel=1", v, 5);
    wr(A_CS, 3);
    cycles(3); rd(A_CNT, v); check("R2 resume phase", v, 5);
    cycles(1); rd(A_CNT, v); check("R2 resume tick", v, 6);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(A_CNT, 32'hFFFF_FFFF);
    cycles(3); rd(A_CNT, v); check("R3 hold at max", v, 32'hFFFF_FFFF);
    cycles(1); rd(A_CNT, v); check("R3 wrap to zero", v, 0);
  endtask

  task automatic t_alarm0();
    logic [31:0] v;
    wr(A_AL0, 102); rd(A_AL0, v); check("R5 alarm0 readback", v, 102);
    wr(A_ST, 32'h17);
    wr(A_CNT, 100);
    cycles(4); rd(A_ST, v); check("R5 alarm0 not yet", v & 32'h1, 0);
    check("R9 irq low before alarm", {31'd0, irq}, 0);
    cycles(4); rd(A_CNT, v); check("R5 counter at alarm", v, 102);
    rd(A_ST, v); check("R5 alarm0 flag set", v & 32'h1, 1);
    check("R9 irq on alarm0", {31'd0, irq}, 1);
    wr(A_ST, 32'h04); rd(A_ST, v); check("R7 write 0 keeps flag", v & 32'h1, 1);
    wr(A_ST, 32'h05); rd(A_ST, v); check("R7 write 1 clears flag", v & 32'h1, 0);
    check("R9 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_alarm1();
    logic [31:0] v;
    wr(A_ST, 32'h13);
    wr(A_AL1, 50);
    wr(A_CNT, 49);
    cycles(4); rd(A_CNT, v); check("R5 counter reached alarm1", v, 50);
    rd(A_ST, v); check("R5 alarm1 disabled no flag", v & 32'h10, 0);
    check("R9 irq low when disabled", {31'd0, irq}, 0);
    wr(A_ST, 32'h40);
    wr(A_CNT, 49);
    cycles(4); rd(A_ST, v); check("R5 alarm1 flag set", v & 32'h10, 32'h10);
    check("R9 irq on alarm1", {31'd0, irq}, 1);
    wr(A_ST, 32'h50); rd(A_ST, v); check("R7 alarm1 cleared", v & 32'h10, 0);
    wr(A_ST, 32'h13);
  endtask

  task automatic t_tick_flag();
    logic [31:0] v;
    wr(A_CNT, 200);
    wr(A_ST, 32'h02); rd(A_ST, v); check("R7 tick flag cleared", v & 32'h2, 0);
    cycles(2); rd(A_ST, v); check("R6 tick flag set while disabled", v & 32'h2, 2);
    check("R9 irq masked by tick enable", {31'd0, irq}, 0);
    wr(A_CNT, 200);
    cycles(2);
    wr(A_ST, 32'h0A);
    rd(A_ST, v); check("R7 set wins over clear", v & 32'h2, 2);
    check("R9 irq on tick with enable", {31'd0, irq}, 1);
    wr(A_ST, 32'h0A); rd(A_ST, v); check("R7 tick clear off-edge", v & 32'h2, 0);
    check("R9 irq drops", {31'd0, irq}, 0);
    wr(A_ST, 32'h13);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, v);
    check("R8 reserved bits zero", v & 32'hFFFF_FFA0, 0);
    check("R8 enables readable", v & 32'h4C, 32'h4C);
    wr(A_ST, 32'h13); rd(A_ST, v); check("R8 enables cleared", v & 32'h4C, 0);
  endtask

  task automatic t_scratch();
    logic [31:0] v;
    wr(A_SCR, 32'hDEAD_BEEF); rd(A_SCR, v); check("R11 scratch readback", v, 32'hDEAD_BEEF);
    wr(A_NONE, 32'h1234_5678); rd(A_NONE, v); check("R11 unmapped reads 0", v, 0);
    rd(A_SCR, v); check("R11 scratch untouched", v, 32'hDEAD_BEEF);
    rd(A_AL1, v); check("R11 alarm1 untouched", v, 50);
    rd(A_AL0, v); check("R11 alarm0 untouched", v, 102);
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    ref_en = 1'b1;
    cycles(2);
    t_tick_period();
    t_clksel();
    t_wrap();
    t_alarm0();
    t_alarm1();
    t_tick_flag();
    t_reserved();
    t_scratch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule